// File: doc/BRIEF.md
# Watchdog Timer with Keyed Start/Stop

This block is a system watchdog. A 32-bit up-counter advances on a slow functional time base, optionally slowed by a power-of-two prescaler. When the counter steps past its all-ones value, the block flags an overflow event and drives a reset request to the chip's reset logic. Software keeps the system alive by kicking the counter. A kick is a write to the trigger register with a value that differs from the one last stored there, and it reloads the counter from the load register.

Software reaches the block through a simple 32-bit register bus with a byte address. The functional clock is modelled as a one-cycle strobe, `func_tick`, on the bus clock. Every write to a posted register is staged and takes effect on the next strobe. Until then, a per-register pending bit reports that the write is still outstanding. The counter starts or stops only after a two-word key sequence. A stray write therefore cannot disarm the watchdog. An early-warning event fires when the counter reaches a programmable delay value.

Two state machines run the block. The key sequencer has the states KEY_IDLE, KEY_ARM_STOP and KEY_ARM_START. It moves from KEY_IDLE to KEY_ARM_STOP on 0xAAAA and to KEY_ARM_START on 0xBBBB. From an armed state, the matching second word emits a stop or start command and returns to KEY_IDLE. A first word re-arms the sequencer, and any other word returns it to KEY_IDLE. The run machine has the states RUN_OFF, RUN_COUNT, RUN_FIRE and RUN_HOLD:
- RUN_OFF and RUN_HOLD go to RUN_COUNT on a start command.
- RUN_COUNT and RUN_HOLD go to RUN_OFF on a stop command.
- RUN_COUNT goes to RUN_FIRE on overflow.
- RUN_FIRE goes to RUN_HOLD after the pulse length.
- A soft reset sends every state to RUN_OFF.

Top module: `wdt_timer`

## Requirements
- R1: After reset the timer is stopped, the ctrl (0x24), counter (0x28), load (0x2C), trigger (0x30), delay (0x44), pending (0x34), raw (0x54) and enable (0x5C) registers read 0, and `reset_req` and `irq` are low.
- R2: Writing a 1 to bit 1 of the system control register (0x10) makes that bit read 1 until the next functional tick. On that tick, every register and both state machines return to their reset values and the bit reads 0 again.
- R3: Register 0x34 holds one pending bit for each posted register: bit 0 ctrl, bit 1 counter, bit 2 load, bit 3 trigger, bit 4 key (0x48), bit 5 delay. A bit is set by a bus write to its register and clears on the next functional tick, when the written value takes effect.
- R4: The ctrl register holds a prescaler enable at bit 5 and a ratio at bits 4:2. While running, the counter advances once every 2^ratio ticks when the prescaler is enabled, and on every tick when it is not.
- R5: Writing 0xBBBB and then 0x4444 to the key register (0x48), as consecutive key writes, starts the counter. Bit 0 of the status register (0x14) reads 1 while it counts. Counting begins on the tick after the start takes effect.
- R6: Writing 0xAAAA and then 0x5555 as consecutive key writes stops the counter. The counter then holds its value and status bit 0 reads 0.
- R7: Any other key sequence has no effect on whether the timer runs. This includes a second word alone, a pair broken by another value, and a mismatched pair.
- R8: A trigger write whose value differs from the stored trigger value reloads the counter from the load register. A trigger write with the same value leaves the counter unchanged.
- R9: When the running counter steps from 0xFFFFFFFF it wraps to 0. On the same step, raw interrupt bit 0 (0x54) sets and `reset_req` rises.
- R10: `reset_req` stays high for exactly 4 functional ticks after the overflow and then falls. The counter then holds until a start command or a soft reset.
- R11: When the running counter steps to a value equal to the delay register, raw interrupt bit 1 sets.
- R12: Raw bits clear when 1 is written to them at 0x54 or 0x58. Writing 1s at 0x5C sets enable bits, and writing 1s at 0x60 clears them; both addresses read the enables. 0x58 reads raw AND enable, and `irq` is the OR of those masked bits.
- R13: A write to the counter register (0x28) loads the counter directly on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_tick | input | 1 | One-cycle strobe marking a functional clock edge |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable when selected |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| reset_req | output | 1 | Reset request pulse after overflow |
| irq | output | 1 | OR of the masked interrupt status bits |

## Verification
The bench sweeps every prescaler ratio with the prescaler on and off. For each setting it counts the ticks to overflow and compares the total with 4·2^ratio; an off-by-one prescaler compare would move the overflow tick. It also checks the exact pulse width, so a pulse that is one tick long or short, or a counter that keeps running after the pulse, is caught. The key tests cover a lone second word, a pair broken by another value, a mismatched pair, and a stop sequence that is abandoned while the timer runs. A sequencer that remembered a stale first word would start or stop on one of these. The bench also writes the same trigger value twice to show that an equal value does not kick. Soft reset and the pending bits are checked before and after the tick, so a write that took effect at once instead of being posted would show up.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int PS_W     = 3;
    localparam int PSC_W    = (1 << PS_W) - 1;
    localparam int NUM_POST = 6;

    // register offsets
    localparam logic [ADDR_W-1:0] OFF_SYSC   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_CNT    = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_LOAD   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_TRG    = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_DLY    = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_IRAW   = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_ISTAT  = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_IENSET = 8'h5C;
    localparam logic [ADDR_W-1:0] OFF_IENCLR = 8'h60;

    // posted register slot indices (also pending bit positions)
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_CNT  = 1;
    localparam int SLOT_LOAD = 2;
    localparam int SLOT_TRG  = 3;
    localparam int SLOT_KEY  = 4;
    localparam int SLOT_DLY  = 5;

    // key words
    localparam logic [DATA_W-1:0] KEY_HALT1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_HALT2 = 32'h0000_5555;
    localparam logic [DATA_W-1:0] KEY_GO1   = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_GO2   = 32'h0000_4444;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_ARM_STOP,
        KEY_ARM_START
    } key_state_e;

    typedef enum logic [1:0] {
        RUN_OFF,
        RUN_COUNT,
        RUN_FIRE,
        RUN_HOLD
    } run_state_e;

    function automatic logic [ADDR_W-1:0] post_offset(input int idx);
        case (idx)
            SLOT_CTRL: return OFF_CTRL;
            SLOT_CNT:  return OFF_CNT;
            SLOT_LOAD: return OFF_LOAD;
            SLOT_TRG:  return OFF_TRG;
            SLOT_KEY:  return OFF_KEY;
            default:   return OFF_DLY;
        endcase
    endfunction

endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         tick,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    output logic         pend,
    output logic [W-1:0] stage
);

    // A write parks its data here; the next functional tick consumes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            stage <= '0;
        end else if (flush) begin
            pend  <= 1'b0;
        end else if (wr_hit) begin
            pend  <= 1'b1;
            stage <= wdata;
        end else if (tick) begin
            pend  <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_word,
    output logic              start_p,
    output logic              stop_p
);

    key_state_e state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= state_nxt;
    end

    // next state: a first word always (re)arms, anything else disarms
    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = KEY_IDLE;
        end else if (key_valid) begin
            if (key_word == KEY_HALT1)    state_nxt = KEY_ARM_STOP;
            else if (key_word == KEY_GO1) state_nxt = KEY_ARM_START;
            else                          state_nxt = KEY_IDLE;
        end
    end

    // outputs (Mealy): command emitted when the second word completes a pair
    always_comb begin
        start_p = 1'b0;
        stop_p  = 1'b0;
        if (key_valid && !clr) begin
            unique case (state)
                KEY_IDLE:      ;
                KEY_ARM_STOP:  stop_p  = (key_word == KEY_HALT2);
                KEY_ARM_START: start_p = (key_word == KEY_GO2);
                default:       ;
            endcase
        end
    end

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              pre_en,
    input  logic [PS_W-1:0]   ratio,
    input  logic              cfg_chg,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_value,
    input  logic [DATA_W-1:0] delay_val,
    output logic [DATA_W-1:0] cnt,
    output logic              running,
    output logic              reset_req,
    output logic              ovf_ev,
    output logic              dly_ev
);

    localparam int PL_W = $clog2(PULSE_LEN + 1);
    localparam logic [PSC_W-1:0]  PSC_ONES = '1;
    localparam logic [DATA_W-1:0] CNT_ONES = '1;

    run_state_e       state, state_nxt;
    logic [PSC_W-1:0] ps_cnt;
    logic [PSC_W-1:0] ps_lim;
    logic [PL_W-1:0]  pulse_cnt;
    logic             step;
    logic             ps_clear;

    assign ps_lim = PSC_ONES >> (PSC_W - int'(ratio));

    // one counter increment happens on this tick
    assign step = tick && (state == RUN_COUNT) && !stop_p && !ld_valid
                  && !cfg_chg && (!pre_en || (ps_cnt == ps_lim));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RUN_OFF;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = RUN_OFF;
        end else if (tick) begin
            unique case (state)
                RUN_OFF:   if (start_p) state_nxt = RUN_COUNT;
                RUN_COUNT: begin
                    if (stop_p)                        state_nxt = RUN_OFF;
                    else if (step && cnt == CNT_ONES)  state_nxt = RUN_FIRE;
                end
                RUN_FIRE:  if (pulse_cnt == PL_W'(PULSE_LEN - 1)) state_nxt = RUN_HOLD;
                RUN_HOLD: begin
                    if (start_p)     state_nxt = RUN_COUNT;
                    else if (stop_p) state_nxt = RUN_OFF;
                end
                default:   state_nxt = RUN_OFF;
            endcase
        end
    end

    assign ps_clear = ld_valid || cfg_chg ||
                      (state != RUN_COUNT && state_nxt == RUN_COUNT);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            ps_cnt    <= '0;
            pulse_cnt <= '0;
        end else if (clr) begin
            cnt       <= '0;
            ps_cnt    <= '0;
            pulse_cnt <= '0;
        end else if (tick) begin
            if (ld_valid)  cnt <= ld_value;
            else if (step) cnt <= cnt + 1'b1;

            if (ps_clear)
                ps_cnt <= '0;
            else if (state == RUN_COUNT && pre_en)
                ps_cnt <= (ps_cnt == ps_lim) ? '0 : ps_cnt + 1'b1;

            if (state == RUN_FIRE) pulse_cnt <= pulse_cnt + 1'b1;
            else                   pulse_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        running   = (state == RUN_COUNT);
        reset_req = (state == RUN_FIRE);
        ovf_ev    = step && (cnt == CNT_ONES);
        dly_ev    = step && (cnt != CNT_ONES) && ((cnt + 1'b1) == delay_val);
    end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              func_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req,
    output logic              irq
);

    logic                wr_en;
    logic                sys_pend;
    logic                soft_go;
    logic [NUM_POST-1:0] pend;
    logic [DATA_W-1:0]   stage [NUM_POST];
    logic [NUM_POST-1:0] apply;

    logic                pre_en_q;
    logic [PS_W-1:0]     ratio_q;
    logic [DATA_W-1:0]   load_q;
    logic [DATA_W-1:0]   trig_q;
    logic [DATA_W-1:0]   dly_q;
    logic [1:0]          irq_raw;
    logic [1:0]          irq_en;
    logic [1:0]          w1c;

    logic                kick;
    logic                ld_valid;
    logic [DATA_W-1:0]   ld_value;
    logic [DATA_W-1:0]   cnt_val;
    logic                running;
    logic                ovf_ev;
    logic                dly_ev;
    logic                start_p;
    logic                stop_p;

    assign wr_en   = bus_sel && bus_we;
    assign soft_go = func_tick && sys_pend;

    // soft reset request: visible until the functional side consumes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          sys_pend <= 1'b0;
        else if (func_tick)                                  sys_pend <= 1'b0;
        else if (wr_en && bus_addr == OFF_SYSC && bus_wdata[1]) sys_pend <= 1'b1;
    end

    // posted write slots
    for (genvar g = 0; g < NUM_POST; g++) begin : g_post
        wdt_post_slot #(.W(DATA_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (soft_go),
            .tick   (func_tick),
            .wr_hit (wr_en && (bus_addr == post_offset(g))),
            .wdata  (bus_wdata),
            .pend   (pend[g]),
            .stage  (stage[g])
        );
        assign apply[g] = func_tick && pend[g] && !soft_go;
    end

    // functional-side copies of the configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_en_q <= 1'b0;
            ratio_q  <= '0;
            load_q   <= '0;
            trig_q   <= '0;
            dly_q    <= '0;
        end else if (soft_go) begin
            pre_en_q <= 1'b0;
            ratio_q  <= '0;
            load_q   <= '0;
            trig_q   <= '0;
            dly_q    <= '0;
        end else begin
            if (apply[SLOT_CTRL]) begin
                pre_en_q <= stage[SLOT_CTRL][5];
                ratio_q  <= stage[SLOT_CTRL][4:2];
            end
            if (apply[SLOT_LOAD]) load_q <= stage[SLOT_LOAD];
            if (apply[SLOT_TRG])  trig_q <= stage[SLOT_TRG];
            if (apply[SLOT_DLY])  dly_q  <= stage[SLOT_DLY];
        end
    end

    // kick only on a changed trigger value; direct counter write wins
    assign kick     = apply[SLOT_TRG] && (stage[SLOT_TRG] != trig_q);
    assign ld_valid = apply[SLOT_CNT] || kick;
    assign ld_value = apply[SLOT_CNT]  ? stage[SLOT_CNT]  :
                      apply[SLOT_LOAD] ? stage[SLOT_LOAD] : load_q;

    wdt_key_seq u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_go),
        .key_valid (apply[SLOT_KEY]),
        .key_word  (stage[SLOT_KEY]),
        .start_p   (start_p),
        .stop_p    (stop_p)
    );

    wdt_count_core #(.PULSE_LEN(PULSE_LEN)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (func_tick),
        .clr       (soft_go),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .pre_en    (pre_en_q),
        .ratio     (ratio_q),
        .cfg_chg   (apply[SLOT_CTRL]),
        .ld_valid  (ld_valid),
        .ld_value  (ld_value),
        .delay_val (dly_q),
        .cnt       (cnt_val),
        .running   (running),
        .reset_req (reset_req),
        .ovf_ev    (ovf_ev),
        .dly_ev    (dly_ev)
    );

    // interrupt status and enables
    assign w1c = (wr_en && (bus_addr == OFF_IRAW || bus_addr == OFF_ISTAT))
                 ? bus_wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_raw <= '0;
            irq_en  <= '0;
        end else if (soft_go) begin
            irq_raw <= '0;
            irq_en  <= '0;
        end else begin
            irq_raw <= (irq_raw & ~w1c) | {dly_ev, ovf_ev};
            if (wr_en && bus_addr == OFF_IENSET)
                irq_en <= irq_en | bus_wdata[1:0];
            else if (wr_en && bus_addr == OFF_IENCLR)
                irq_en <= irq_en & ~bus_wdata[1:0];
        end
    end

    assign irq = |(irq_raw & irq_en);

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_SYSC:   bus_rdata = {30'd0, sys_pend, 1'b0};
            OFF_STAT:   bus_rdata = {31'd0, running};
            OFF_CTRL:   bus_rdata = {26'd0, pre_en_q, ratio_q, 2'b00};
            OFF_CNT:    bus_rdata = cnt_val;
            OFF_LOAD:   bus_rdata = load_q;
            OFF_TRG:    bus_rdata = trig_q;
            OFF_PEND:   bus_rdata = {{(DATA_W-NUM_POST){1'b0}}, pend};
            OFF_DLY:    bus_rdata = dly_q;
            OFF_IRAW:   bus_rdata = {30'd0, irq_raw};
            OFF_ISTAT:  bus_rdata = {30'd0, irq_raw & irq_en};
            OFF_IENSET,
            OFF_IENCLR: bus_rdata = {30'd0, irq_en};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
    parameter int PULSE_LEN = 4,
    parameter int NP        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          func_tick,
    input  logic          wr_en,
    input  logic          reset_req,
    input  logic          running,
    input  logic [NP-1:0] pend,
    input  logic [31:0]   cnt_val,
    input  logic [1:0]    irq_raw,
    input  logic          start_p,
    input  logic          stop_p
);

    int unsigned req_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          req_ticks <= 0;
        else if (!reset_req) req_ticks <= 0;
        else if (func_tick)  req_ticks <= req_ticks + 1;
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            AST_REQ_LEN: assert (req_ticks <= PULSE_LEN)
                else $error("reset request held too long"); // R10
        end
    end

    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        func_tick && !wr_en |=> pend == '0); // R3

    AST_CNT_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !func_tick |=> $stable(cnt_val)); // R4

    AST_REQ_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !func_tick |=> $stable(reset_req)); // R10

    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> irq_raw[0]); // R9

    AST_KEY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, stop_p})); // R5

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !running); // R6

endmodule

bind wdt_timer wdt_timer_chk #(.PULSE_LEN(PULSE_LEN), .NP(wdt_pkg::NUM_POST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_tick (func_tick),
    .wr_en     (wr_en),
    .reset_req (reset_req),
    .running   (running),
    .pend      (pend),
    .cnt_val   (cnt_val),
    .irq_raw   (irq_raw),
    .start_p   (start_p),
    .stop_p    (stop_p)
);

// File: tb/wdt_timer_bench.sv
`timescale 1ns/1ps
module wdt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        func_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        reset_req;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    wdt_timer u_wdt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_tick (func_tick),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reset_req (reset_req),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); func_tick = 1'b1;
            @(negedge clk); func_tick = 1'b0;
        end
    endtask

    task automatic key(input logic [31:0] w);
        wr(8'h48, w);
        tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h24, rv); chk("R1 ctrl", rv, 0);
        rd(8'h28, rv); chk("R1 counter", rv, 0);
        rd(8'h2C, rv); chk("R1 load", rv, 0);
        rd(8'h34, rv); chk("R1 pending", rv, 0);
        rd(8'h14, rv); chk("R1 status", rv, 0);
        rd(8'h54, rv); chk("R1 raw", rv, 0);
        chk("R1 reset_req", {31'd0, reset_req}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R3 posted writes, R13 counter load
        wr(8'h24, 32'h0); wr(8'h28, 32'h10); wr(8'h2C, 32'h1234);
        wr(8'h30, 32'h0); wr(8'h48, 32'h99); wr(8'h44, 32'h7);
        rd(8'h34, rv); chk("R3 all pending", rv, 32'h3F);
        rd(8'h2C, rv); chk("R3 load not yet applied", rv, 0);
        tick(1);
        rd(8'h34, rv); chk("R3 pending drained", rv, 0);
        rd(8'h2C, rv); chk("R3 load applied", rv, 32'h1234);
        rd(8'h44, rv); chk("R3 delay applied", rv, 32'h7);
        rd(8'h28, rv); chk("R13 counter written", rv, 32'h10);
        wr(8'h2C, 32'h1234);
        rd(8'h34, rv); chk("R3 load bit alone", rv, 32'h4);
        tick(1);

        // R8 trigger
        wr(8'h30, 32'h1); tick(1);
        rd(8'h28, rv); chk("R8 kick reloads", rv, 32'h1234);
        wr(8'h28, 32'h55); tick(1);
        wr(8'h30, 32'h1); tick(1);
        rd(8'h28, rv); chk("R8 same value no kick", rv, 32'h55);
        wr(8'h30, 32'h2); tick(1);
        rd(8'h28, rv); chk("R8 new value kicks", rv, 32'h1234);

        // R7 bad key sequences
        key(32'h4444); tick(3);
        rd(8'h14, rv); chk("R7 lone second word", rv, 0);
        key(32'hBBBB); key(32'h1234); key(32'h4444); tick(3);
        rd(8'h14, rv); chk("R7 broken pair", rv, 0);
        key(32'hBBBB); key(32'h5555); tick(3);
        rd(8'h14, rv); chk("R7 mismatched pair", rv, 0);
        rd(8'h28, rv); chk("R7 counter untouched", rv, 32'h1234);

        // R5 start
        key(32'hBBBB); key(32'h4444);
        rd(8'h14, rv); chk("R5 running", rv, 1);
        tick(3);
        rd(8'h28, rv); chk("R5 counting", rv, 32'h1237);
        // R7 abandoned stop while running
        key(32'hAAAA); key(32'h4444);
        rd(8'h14, rv); chk("R7 still running", rv, 1);
        rd(8'h28, rv); chk("R7 kept counting", rv, 32'h1239);
        // R6 stop
        key(32'hAAAA); key(32'h5555); tick(3);
        rd(8'h14, rv); chk("R6 stopped", rv, 0);
        rd(8'h28, rv); chk("R6 counter holds", rv, 32'h123A);

        // R4 R9 R10 R11 sweep over prescaler settings
        for (int pre = 0; pre < 2; pre++) begin
            for (int r = 0; r < 8; r++) begin
                int stp;
                stp = (pre != 0) ? (1 << r) : 1;
                wr(8'h24, (32'(pre) << 5) | (32'(r) << 2));
                wr(8'h2C, 32'hFFFF_FFFC);
                wr(8'h28, 32'hFFFF_FFFC);
                wr(8'h44, 32'hFFFF_FFFE);
                wr(8'h54, 32'h3);
                tick(1);
                key(32'hBBBB); key(32'h4444);
                tick(stp);
                rd(8'h28, rv); chk($sformatf("R4 first step pre%0d r%0d", pre, r), rv, 32'hFFFF_FFFD);
                rd(8'h54, rv); chk("R11 no early warning yet", rv & 32'h2, 0);
                tick(stp);
                rd(8'h54, rv); chk("R11 early warning", rv & 32'h2, 32'h2);
                tick(2 * stp - 1);
                rd(8'h28, rv); chk($sformatf("R4 last value pre%0d r%0d", pre, r), rv, 32'hFFFF_FFFF);
                chk("R9 no request before overflow", {31'd0, reset_req}, 0);
                tick(1);
                chk("R9 request on overflow", {31'd0, reset_req}, 1);
                rd(8'h54, rv); chk("R9 overflow flag", rv & 32'h1, 1);
                rd(8'h28, rv); chk("R9 counter wrapped", rv, 0);
                tick(3);
                chk("R10 pulse still high", {31'd0, reset_req}, 1);
                tick(1);
                chk("R10 pulse ended", {31'd0, reset_req}, 0);
                tick(5);
                rd(8'h28, rv); chk("R10 counter holds", rv, 0);
                rd(8'h14, rv); chk("R10 not running", rv, 0);
            end
        end

        // R12 interrupt masking and clearing (raw = 3 now)
        rd(8'h58, rv); chk("R12 masked off", rv, 0);
        chk("R12 irq low", {31'd0, irq}, 0);
        wr(8'h5C, 32'h1);
        rd(8'h5C, rv); chk("R12 enable set", rv, 1);
        rd(8'h58, rv); chk("R12 masked status", rv, 1);
        chk("R12 irq high", {31'd0, irq}, 1);
        wr(8'h60, 32'h1);
        rd(8'h60, rv); chk("R12 enable cleared", rv, 0);
        chk("R12 irq dropped", {31'd0, irq}, 0);
        wr(8'h5C, 32'h3);
        wr(8'h54, 32'h1);
        rd(8'h54, rv); chk("R12 raw w1c", rv, 32'h2);
        rd(8'h58, rv); chk("R12 masked after w1c", rv, 32'h2);
        wr(8'h58, 32'h2);
        rd(8'h54, rv); chk("R12 status w1c", rv, 0);
        chk("R12 irq clear", {31'd0, irq}, 0);

        // R2 soft reset
        wr(8'h54, 32'h0);
        key(32'hBBBB); key(32'h4444);
        wr(8'h5C, 32'h3);
        wr(8'h10, 32'h2);
        rd(8'h10, rv); chk("R2 reset in progress", rv, 32'h2);
        rd(8'h2C, rv); chk("R2 load before tick", rv, 32'hFFFF_FFFC);
        tick(1);
        rd(8'h10, rv); chk("R2 reset done", rv, 0);
        rd(8'h2C, rv); chk("R2 load cleared", rv, 0);
        rd(8'h24, rv); chk("R2 ctrl cleared", rv, 0);
        rd(8'h44, rv); chk("R2 delay cleared", rv, 0);
        rd(8'h5C, rv); chk("R2 enables cleared", rv, 0);
        rd(8'h14, rv); chk("R2 stopped", rv, 0);
        rd(8'h28, rv); chk("R2 counter cleared", rv, 0);
        tick(3);
        rd(8'h28, rv); chk("R2 stays stopped", rv, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule